// File: doc/BRIEF.md
# USB packet error status unit

This block collects the receive error strobes of a full-speed USB serial engine into an 8-bit sticky status register. Each error source raises its own status bit in the same clock edge that its one-cycle strobe is sampled. The bit is set as soon as the engine detects the fault, not when the token ends. A status bit stays set until software writes a one to its position. A separate 8-bit enable mask selects which status bits contribute to a single registered error interrupt line.

Both registers share one small write port. When `wr_sel` is 0, a write clears the status bits marked with ones in `wr_data`. When `wr_sel` is 1, the write loads the enable mask. Bit 6 is reserved in both registers and always reads 0. Serial decoding and CRC computation are handled upstream; this unit only sees the finished event strobes.

Top module: `usb_err_status_unit`

## Requirements
- R1: After a synchronous active-low reset, `status`, `enable` and `err_irq` are all 0.
- R2: A strobe that is high at a rising edge sets its status bit at that edge. The bit positions are: `ev_bitstuff` to bit 7, `ev_dma` to bit 5, `ev_turnaround` to bit 4, `ev_misalign` to bit 3, `ev_crc16` to bit 2, `ev_crc5` to bit 1 and `ev_pid` to bit 0.
- R3: A write with `wr_sel`=0 clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R4: If a set strobe and a write-one clear reach the same status bit at the same edge, the bit ends up set.
- R5: Status bit 6 always reads 0, whatever strobes or writes arrive.
- R6: A write with `wr_sel`=1 loads `enable` with `wr_data`, with bit 6 forced to 0. This write leaves `status` unchanged. A write with `wr_sel`=0 leaves `enable` unchanged.
- R7: `err_irq` equals the OR of (`status` AND `enable`) as they stood one clock earlier.
- R8: With no strobe and no clearing write, every status bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bitstuff | input | 1 | Bit-stuff violation strobe |
| ev_dma | input | 1 | DMA grant miss or buffer overrun strobe |
| ev_turnaround | input | 1 | Bus turnaround timeout strobe |
| ev_misalign | input | 1 | Data field not a whole number of bytes strobe |
| ev_crc16 | input | 1 | Data packet CRC16 failure strobe |
| ev_crc5 | input | 1 | Token CRC5 failure strobe (peripheral mode) |
| ev_pid | input | 1 | PID check failure strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: clear status with ones, 1: load enable mask |
| wr_data | input | 8 | Write data |
| status | output | 8 | Sticky error status |
| enable | output | 8 | Interrupt enable mask |
| err_irq | output | 1 | Registered combined error flag |

## Verification
The assertions check the following on every cycle:
- the reserved bit stays at zero;
- each cell sets on its strobe even when a clear hits it in the same cycle;
- a lone clear empties a cell;
- a cell with neither set nor clear holds its value;
- the interrupt line follows the masked OR of the previous cycle.

Some behaviours can only be shown by the bench's scenarios:
- the mapping of each named strobe to its bit position;
- that the two write targets do not disturb each other;
- the complete range of clear masks and enable values.

// File: rtl/usb_err_pkg.sv
// Package: shared widths and status bit positions of the USB error unit.
// Assumes an 8-bit register layout with one reserved position.
package usb_err_pkg;
    localparam int ERR_W        = 8;
    localparam int POS_BITSTUFF = 7;
    localparam int POS_RSVD     = 6;
    localparam int POS_DMA      = 5;
    localparam int POS_TURN     = 4;
    localparam int POS_ALIGN    = 3;
    localparam int POS_CRC16    = 2;
    localparam int POS_CRC5     = 1;
    localparam int POS_PID      = 0;
    localparam logic [ERR_W-1:0] RSVD_MASK = ERR_W'(1) << POS_RSVD;
endpackage

// File: rtl/err_bit_cell.sv
// err_bit_cell: one sticky status bit. It sets on its strobe and clears on a
// write of one. When both arrive in the same cycle, the set wins.
// Assumes a synchronous active-low reset.
module err_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_r;

    // Sticky flop: reset, then set over clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_r <= 1'b0;
        else if (set_i) q_r <= 1'b1;
        else if (clr_i) q_r <= 1'b0;
    end

    assign q_o = q_r;

    // R4 (and R2): a set strobe always leaves the bit set
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R3
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> !q_o);
endmodule

// File: rtl/err_mask_reg.sv
// err_mask_reg: the interrupt enable register. It loads on a selected write,
// and the reserved positions are forced to zero.
// Assumes a synchronous active-low reset.
module err_mask_reg #(
    parameter int                W     = 8,
    parameter logic [W-1:0]      FIXED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_r;

    // Mask register: load on a write, with the reserved bits held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_r <= '0;
        else if (load_i) mask_r <= data_i & ~FIXED;
    end

    assign mask_o = mask_r;

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mask_o));
endmodule

// File: rtl/err_irq_merge.sv
// err_irq_merge: registered OR of the enabled status bits.
// Assumes the status and mask come from flops, so the output lags them by one cycle.
module err_irq_merge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    logic irq_r;

    // Interrupt flop: sample the masked OR of the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_r <= 1'b0;
        else        irq_r <= |(stat_i & mask_i);
    end

    assign irq_o = irq_r;
endmodule

// File: rtl/usb_err_status_unit.sv
// usb_err_status_unit: collects the USB receive error strobes into sticky
// status bits that are cleared by writing ones. It also holds an enable mask
// and drives a registered combined interrupt.
// Assumes each strobe is high for one cycle per event and that resets are synchronous.
module usb_err_status_unit
    import usb_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_bitstuff,
    input  logic             ev_dma,
    input  logic             ev_turnaround,
    input  logic             ev_misalign,
    input  logic             ev_crc16,
    input  logic             ev_crc5,
    input  logic             ev_pid,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [ERR_W-1:0] wr_data,
    output logic [ERR_W-1:0] status,
    output logic [ERR_W-1:0] enable,
    output logic             err_irq
);
    logic [ERR_W-1:0] set_vec;
    logic [ERR_W-1:0] clr_vec;

    // Event routing: place each strobe at its bit position.
    always_comb begin
        set_vec               = '0;
        set_vec[POS_BITSTUFF] = ev_bitstuff;
        set_vec[POS_DMA]      = ev_dma;
        set_vec[POS_TURN]     = ev_turnaround;
        set_vec[POS_ALIGN]    = ev_misalign;
        set_vec[POS_CRC16]    = ev_crc16;
        set_vec[POS_CRC5]     = ev_crc5;
        set_vec[POS_PID]      = ev_pid;
    end

    // Clear decode: a status write clears the bits written with one.
    always_comb begin
        clr_vec = (wr_en && !wr_sel) ? wr_data : '0;
    end

    for (genvar i = 0; i < ERR_W; i++) begin : g_stat
        if (RSVD_MASK[i]) begin : g_rsvd
            assign status[i] = 1'b0;
        end else begin : g_cell
            err_bit_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q_o   (status[i])
            );
        end
    end

    err_mask_reg #(.W(ERR_W), .FIXED(RSVD_MASK)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (wr_en && wr_sel),
        .data_i (wr_data),
        .mask_o (enable)
    );

    err_irq_merge #(.W(ERR_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (status),
        .mask_i (enable),
        .irq_o  (err_irq)
    );

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[POS_RSVD] == 1'b0) && (enable[POS_RSVD] == 1'b0));
    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!rst_n) |-> (err_irq == |($past(status) & $past(enable))));
endmodule

// File: tb/test_usb_err_status_unit.sv
module test_usb_err_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ev = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] status, enable;
    logic       err_irq;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    usb_err_status_unit i_usb_err_status_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_bitstuff(ev[6]), .ev_dma(ev[5]), .ev_turnaround(ev[4]),
        .ev_misalign(ev[3]), .ev_crc16(ev[2]), .ev_crc5(ev[1]), .ev_pid(ev[0]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status(status), .enable(enable), .err_irq(err_irq)
    );

    function automatic logic [7:0] place(input logic [6:0] e);
        return {e[6], 1'b0, e[5:0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply the inputs for one edge, then sample on the falling edge after it.
    task automatic step(input logic [6:0] e, input logic we, input logic sel, input logic [7:0] d);
        ev = e; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        ev = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_st;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 enable", enable, 8'h00);
        chk("R1 irq", {7'b0, err_irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 and R7: every event pattern, with a rotating enable mask
        for (int p = 0; p < 128; p++) begin
            logic [7:0] m;
            m = 8'(p * 37 + 5);
            step('0, 1'b1, 1'b0, 8'hFF);
            step('0, 1'b1, 1'b1, m);
            chk("R6 enable load", enable, m & 8'hBF);
            step(7'(p), 1'b0, 1'b0, '0);
            exp_st = place(7'(p));
            chk("R2 set mapping", status, exp_st);
            step('0, 1'b0, 1'b0, '0);
            chk("R7 irq", {7'b0, err_irq}, {7'b0, |(exp_st & m & 8'hBF)});
            chk("R8 hold", status, exp_st);
        end

        // R3: set every bit, then sweep all clear masks
        for (int c = 0; c < 256; c++) begin
            step(7'h7F, 1'b0, 1'b0, '0);
            step('0, 1'b1, 1'b0, 8'(c));
            chk("R3 clear", status, 8'hBF & ~8'(c));
            step('0, 1'b1, 1'b0, 8'hFF);
        end

        // R4: a set and a clear on the same bit in the same cycle
        for (int b = 0; b < 7; b++) begin
            step('0, 1'b1, 1'b0, 8'hFF);
            step(7'(1 << b), 1'b1, 1'b0, 8'hFF);
            chk("R4 set wins", status, place(7'(1 << b)));
        end

        // R5: the reserved bit ignores writes of one
        step('0, 1'b1, 1'b1, 8'hFF);
        chk("R5 enable bit6", enable, 8'hBF);
        step(7'h7F, 1'b0, 1'b0, '0);
        chk("R5 status bit6", status & 8'h40, 8'h00);

        // R6: the two write targets do not disturb each other
        step('0, 1'b1, 1'b1, 8'h00);
        chk("R6 enable write keeps status", status, 8'hBF);
        step('0, 1'b1, 1'b1, 8'h21);
        step('0, 1'b1, 1'b0, 8'hFF);
        chk("R6 status write keeps enable", enable, 8'h21);
        step('0, 1'b0, 1'b0, '0);
        chk("R7 irq low after clear", {7'b0, err_irq}, 8'h00);

        // R1: reset again with everything set
        step(7'h7F, 1'b1, 1'b1, 8'hFF);
        rst_n = 1'b0;
        step('0, 1'b0, 1'b0, '0);
        chk("R1 status after reset", status, 8'h00);
        chk("R1 enable after reset", enable, 8'h00);
        chk("R1 irq after reset", {7'b0, err_irq}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule